// File: doc/BRIEF.md
# Fetch Block Prediction Checker

This block sits after pre-decode in an instruction fetch pipeline. It receives one fetch block of up to sixteen 2-byte slots at a time, together with everything the branch predictor claimed about that block: whether it predicted a taken control-flow instruction, in which slot, to which target, and the two candidate instruction ranges. The candidates are the range up to the predicted jump and the range up to the next block when no jump is taken. It checks the claim against the decoded slots and flags five kinds of misprediction. These are an unconditional jump the predictor missed, a missed return, a prediction placed on a slot that does not start a valid instruction in the block, a prediction placed on an ordinary instruction, and a wrong target on a direct jump or branch.

The checker reports the earliest faulty slot as both an index and a one-hot vector, along with a fault class, a corrected target address and a corrected range mask. The range mask is trimmed to end at the first missed jump or return. Every result is registered once, so it appears on the outputs in the cycle after the inputs. Redirect generation and writeback of the results belong to the surrounding logic.

Top module: `fetch_pred_checker`

## Requirements
- R1: All outputs are zero in reset. A block presented with `blk_valid` high produces `chk_valid` high and its results exactly one clock later. A cycle with `blk_valid` low produces `chk_valid`, `fault_any`, `fault_code`, `fault_idx`, `fault_onehot`, `fixed_target` and `fixed_range` all zero one clock later.
- R2: The base range is `jump_range` when `pred_taken` is 1 and `ftr_range` when it is 0. A slot is live when its `slot_start` bit and its base range bit are both 1.
- R3: A live slot with kind 2'b10 (JAL) is a missed-JAL fault (code 1) when `pred_taken` is 0 or `pred_slot` is greater than its index. The corrected target is that slot's PC plus its sign-extended offset.
- R4: A live slot with kind 2'b11 and its `slot_ret` bit set is a missed-return fault (code 2) under the same condition as R3. The corrected target is `ret_addr`.
- R5: When `pred_taken` is 1 and the predicted slot is not live, the fault is invalid-slot (code 3). The corrected target is that slot's PC plus 2 if its `slot_rvc` bit is 1, or plus 4 otherwise.
- R6: When `pred_taken` is 1 and the predicted slot is live with kind 2'b00, the fault is non-CFI (code 4). The corrected target follows the same rule as R5.
- R7: When `pred_taken` is 1 and the predicted slot is live with kind 2'b01 (branch) or 2'b10 (JAL), the fault is wrong-target (code 5) if `pred_target` differs from that slot's PC plus its sign-extended offset. The corrected target is that sum. Kind 2'b11 at the predicted slot is never a fault.
- R8: When several slots are faulty, the lowest-indexed one is reported. `fault_idx` holds its index, `fault_onehot` has only that bit set, and `fault_any` is 1. With no fault, `fault_any`, `fault_idx`, `fault_onehot` and `fault_code` are 0.
- R9: `fixed_range` equals the base range with every bit above the first missed JAL or return cleared. When no jump or return is missed, it equals the base range unchanged.
- R10: For a valid block with no fault, `fixed_target` equals `pred_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A fetch block is presented this cycle |
| slot_start | input | SLOTS | 1 where the slot begins an instruction |
| slot_rvc | input | SLOTS | 1 where the instruction is 16-bit |
| slot_kind | input | 2*SLOTS | Per-slot CFI kind: 00 none, 01 branch, 10 JAL, 11 JALR |
| slot_ret | input | SLOTS | 1 where the JALR is a return |
| slot_off | input | OFF_W*SLOTS | Per-slot signed target offset |
| slot_pc | input | PC_W*SLOTS | Per-slot PC |
| pred_taken | input | 1 | Predictor claimed a taken CFI |
| pred_slot | input | IDX_W | Slot of the claimed taken CFI |
| pred_target | input | PC_W | Claimed target |
| ret_addr | input | PC_W | Return address from the return stack |
| jump_range | input | SLOTS | Range up to the predicted jump |
| ftr_range | input | SLOTS | Range up to the next block |
| chk_valid | output | 1 | Registered result valid |
| fault_any | output | 1 | A misprediction was found |
| fault_code | output | 3 | 0 none, 1 JAL, 2 return, 3 invalid slot, 4 non-CFI, 5 target |
| fault_idx | output | IDX_W | Index of the first faulty slot |
| fault_onehot | output | SLOTS | One-hot position of the first faulty slot |
| fixed_target | output | PC_W | Corrected target address |
| fixed_range | output | SLOTS | Corrected in-block range mask |

## Verification
The in-module assertions watch the properties that hold on every cycle. These are the agreement between the one-hot position and the index, quiet outputs after an idle cycle, and a corrected range that never exceeds the selected base range. They also check that the range is trimmed after a missed jump or return, that the return address is used for a missed return, that a fault-free block passes the claimed target through, and that predictor-slot faults point at the claimed slot. The assertions cannot tell whether the right class was chosen, whether the lowest fault won over later ones, or whether the computed fall-through and jump targets are correct. Those only show when the bench compares against its reference model. The bench applies directed blocks for each class and for several faults at once, then a long run of random blocks.

// File: rtl/fetch_pred_checker.sv
module fetch_pred_checker #(
  parameter int SLOTS = 16,
  parameter int PC_W  = 32,
  parameter int OFF_W = 13,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   blk_valid,
  input  logic [SLOTS-1:0]       slot_start,
  input  logic [SLOTS-1:0]       slot_rvc,
  input  logic [2*SLOTS-1:0]     slot_kind,
  input  logic [SLOTS-1:0]       slot_ret,
  input  logic [OFF_W*SLOTS-1:0] slot_off,
  input  logic [PC_W*SLOTS-1:0]  slot_pc,
  input  logic                   pred_taken,
  input  logic [IDX_W-1:0]       pred_slot,
  input  logic [PC_W-1:0]        pred_target,
  input  logic [PC_W-1:0]        ret_addr,
  input  logic [SLOTS-1:0]       jump_range,
  input  logic [SLOTS-1:0]       ftr_range,
  output logic                   chk_valid,
  output logic                   fault_any,
  output logic [2:0]             fault_code,
  output logic [IDX_W-1:0]       fault_idx,
  output logic [SLOTS-1:0]       fault_onehot,
  output logic [PC_W-1:0]        fixed_target,
  output logic [SLOTS-1:0]       fixed_range
);

  localparam logic [2:0] C_NONE = 3'd0, C_JAL = 3'd1, C_RET = 3'd2,
                         C_INV  = 3'd3, C_NCFI = 3'd4, C_TGT = 3'd5;

  logic [SLOTS-1:0] range_sel, jal_miss, ret_miss, inv_err, ncfi_err, tgt_err;
  logic [SLOTS-1:0] fault_vec, miss_vec, first_oh, miss_oh, keep;
  logic [PC_W-1:0]  jmp_tgt [SLOTS];
  logic [PC_W-1:0]  seq_tgt [SLOTS];

  assign range_sel = pred_taken ? jump_range : ftr_range;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [1:0]      kind;
    logic [PC_W-1:0] pc;
    logic [OFF_W-1:0] off;
    logic live, at_pred, before_pred;

    assign kind = slot_kind[2*g +: 2];
    assign pc   = slot_pc[PC_W*g +: PC_W];
    assign off  = slot_off[OFF_W*g +: OFF_W];
    assign jmp_tgt[g] = pc + {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    assign seq_tgt[g] = pc + (slot_rvc[g] ? PC_W'(2) : PC_W'(4));

    assign live        = slot_start[g] & range_sel[g];
    assign at_pred     = pred_taken && (pred_slot == IDX_W'(g));
    assign before_pred = !pred_taken || (pred_slot > IDX_W'(g));

    assign jal_miss[g] = live && kind == 2'b10 && before_pred;
    assign ret_miss[g] = live && kind == 2'b11 && slot_ret[g] && before_pred;
    assign inv_err[g]  = at_pred && !live;
    assign ncfi_err[g] = at_pred && live && kind == 2'b00;
    assign tgt_err[g]  = at_pred && live && (kind == 2'b01 || kind == 2'b10) &&
                         (pred_target != jmp_tgt[g]);
  end

  assign miss_vec  = jal_miss | ret_miss;
  assign fault_vec = miss_vec | inv_err | ncfi_err | tgt_err;
  assign first_oh  = fault_vec & (~fault_vec + SLOTS'(1));
  assign miss_oh   = miss_vec & (~miss_vec + SLOTS'(1));
  assign keep      = (miss_vec == '0) ? '1 : (miss_oh | (miss_oh - SLOTS'(1)));

  logic [IDX_W-1:0] idx_n;
  logic [2:0]       code_n;
  logic [PC_W-1:0]  tgt_n;

  always_comb begin
    idx_n  = '0;
    code_n = C_NONE;
    tgt_n  = pred_target;
    for (int i = 0; i < SLOTS; i++) begin
      if (first_oh[i]) begin
        idx_n = IDX_W'(i);
        if (jal_miss[i]) begin
          code_n = C_JAL;  tgt_n = jmp_tgt[i];
        end else if (ret_miss[i]) begin
          code_n = C_RET;  tgt_n = ret_addr;
        end else if (inv_err[i]) begin
          code_n = C_INV;  tgt_n = seq_tgt[i];
        end else if (ncfi_err[i]) begin
          code_n = C_NCFI; tgt_n = seq_tgt[i];
        end else begin
          code_n = C_TGT;  tgt_n = jmp_tgt[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid    <= 1'b0;
      fault_any    <= 1'b0;
      fault_code   <= C_NONE;
      fault_idx    <= '0;
      fault_onehot <= '0;
      fixed_target <= '0;
      fixed_range  <= '0;
    end else if (blk_valid) begin
      chk_valid    <= 1'b1;
      fault_any    <= |fault_vec;
      fault_code   <= code_n;
      fault_idx    <= idx_n;
      fault_onehot <= first_oh;
      fixed_target <= tgt_n;
      fixed_range  <= range_sel & keep;
    end else begin
      chk_valid    <= 1'b0;
      fault_any    <= 1'b0;
      fault_code   <= C_NONE;
      fault_idx    <= '0;
      fault_onehot <= '0;
      fixed_target <= '0;
      fixed_range  <= '0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> (!fault_any && fixed_range == '0 && fault_onehot == '0));

  assert_onehot_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |-> ($onehot0(fault_onehot) && fault_onehot[fault_idx]));

  assert_range_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> ((fixed_range & ~$past(range_sel)) == '0));

  assert_cut_after_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (fault_code == C_JAL || fault_code == C_RET)) |->
      (((fixed_range >> fault_idx) >> 1) == '0));

  assert_ret_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && fault_code == C_RET) |-> fixed_target == $past(ret_addr));

  assert_pass_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !fault_any) |-> fixed_target == $past(pred_target));

  assert_pred_slot_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && fault_code >= C_INV) |-> fault_idx == $past(pred_slot));

endmodule

// File: tb/fetch_pred_checker_tb_top.sv
`timescale 1ns/1ps
module fetch_pred_checker_tb_top;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        b_valid, b_taken;
  logic [3:0]  b_pslot;
  logic [31:0] b_ptgt, b_ret_addr;
  logic [15:0] b_jr, b_fr, b_start, b_rvc, b_retf;
  logic [1:0]  b_kind [N];
  logic [12:0] b_off  [N];
  logic [31:0] b_pc   [N];

  logic [2*N-1:0]  p_kind;
  logic [13*N-1:0] p_off;
  logic [32*N-1:0] p_pc;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      p_kind[2*i +: 2]  = b_kind[i];
      p_off[13*i +: 13] = b_off[i];
      p_pc[32*i +: 32]  = b_pc[i];
    end
  end

  logic        chk_valid, fault_any;
  logic [2:0]  fault_code;
  logic [3:0]  fault_idx;
  logic [15:0] fault_onehot, fixed_range;
  logic [31:0] fixed_target;

  fetch_pred_checker dut_i (
    .clk(clk), .rst_n(rst_n), .blk_valid(b_valid),
    .slot_start(b_start), .slot_rvc(b_rvc), .slot_kind(p_kind), .slot_ret(b_retf),
    .slot_off(p_off), .slot_pc(p_pc), .pred_taken(b_taken), .pred_slot(b_pslot),
    .pred_target(b_ptgt), .ret_addr(b_ret_addr), .jump_range(b_jr), .ftr_range(b_fr),
    .chk_valid(chk_valid), .fault_any(fault_any), .fault_code(fault_code),
    .fault_idx(fault_idx), .fault_onehot(fault_onehot),
    .fixed_target(fixed_target), .fixed_range(fixed_range));

  int tests = 0, fails = 0;
  bit done = 0;

  logic        e_valid, e_any;
  logic [2:0]  e_code;
  logic [3:0]  e_idx;
  logic [15:0] e_oh, e_range;
  logic [31:0] e_tgt;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] upto(int n);
    logic [31:0] m;
    m = (32'd1 << (n + 1)) - 32'd1;
    return m[15:0];
  endfunction

  function automatic logic [31:0] sext(logic [12:0] o);
    return {{19{o[12]}}, o};
  endfunction

  task automatic model();
    logic [15:0] rng;
    int first;
    logic [2:0] c;
    bit inblk, here, earlier;
    logic [31:0] tgt;
    first = -1; c = 3'd0;
    rng = b_taken ? b_jr : b_fr;
    for (int i = 0; i < N; i++) begin
      inblk   = b_start[i] && rng[i];
      here    = b_taken && (int'(b_pslot) == i);
      earlier = !b_taken || (int'(b_pslot) > i);
      tgt     = b_pc[i] + sext(b_off[i]);
      if (first < 0) begin
        if (inblk && b_kind[i] == 2'b10 && earlier) c = 3'd1;
        else if (inblk && b_kind[i] == 2'b11 && b_retf[i] && earlier) c = 3'd2;
        else if (here && !inblk) c = 3'd3;
        else if (here && b_kind[i] == 2'b00) c = 3'd4;
        else if (here && b_kind[i] != 2'b11 && tgt != b_ptgt) c = 3'd5;
        if (c != 3'd0) first = i;
      end
    end
    e_valid = b_valid; e_any = (c != 0); e_code = c;
    e_idx = (first < 0) ? 4'd0 : 4'(first);
    e_oh  = (first < 0) ? 16'd0 : (16'd1 << first);
    e_range = rng;
    if (c == 3'd1 || c == 3'd2)
      for (int i = first + 1; i < N; i++) e_range[i] = 1'b0;
    case (c)
      3'd1, 3'd5: e_tgt = b_pc[first] + sext(b_off[first]);
      3'd2:       e_tgt = b_ret_addr;
      3'd3, 3'd4: e_tgt = b_pc[first] + (b_rvc[first] ? 32'd2 : 32'd4);
      default:    e_tgt = b_ptgt;
    endcase
    if (!b_valid) begin
      e_any = 0; e_code = 0; e_idx = 0; e_oh = 0; e_range = 0; e_tgt = 0;
    end
  endtask

  task automatic apply(string req);
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R1", "chk_valid", 64'(chk_valid), 64'(e_valid));
    chk(req, "fault_any", 64'(fault_any), 64'(e_any));
    chk(req, "fault_code", 64'(fault_code), 64'(e_code));
    chk("R8", "fault_idx", 64'(fault_idx), 64'(e_idx));
    chk("R8", "fault_onehot", 64'(fault_onehot), 64'(e_oh));
    chk(req, "fixed_target", 64'(fixed_target), 64'(e_tgt));
    chk("R9", "fixed_range", 64'(fixed_range), 64'(e_range));
  endtask

  task automatic base();
    b_valid = 1; b_taken = 0; b_pslot = 0; b_ptgt = 32'h0;
    b_ret_addr = 32'h8000_4440; b_jr = 16'hFFFF; b_fr = 16'hFFFF;
    b_start = 16'hFFFF; b_rvc = 16'hFFFF; b_retf = 16'h0;
    for (int i = 0; i < N; i++) begin
      b_kind[i] = 2'b00;
      b_off[i]  = 13'(8 + 2 * i);
      b_pc[i]   = 32'h8000_1000 + 32'(2 * i);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    base();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset chk_valid", 64'(chk_valid), 64'd0);
    chk("R1", "reset fault_any", 64'(fault_any), 64'd0);
    chk("R1", "reset fixed_target", 64'(fixed_target), 64'd0);
    chk("R1", "reset fixed_range", 64'(fixed_range), 64'd0);
    rst_n = 1;

    // R2, R10: clean fall-through block, partial range
    base(); b_fr = upto(9); apply("R2");
    // R2: taken branch correct target, jump range selected
    base(); b_taken = 1; b_pslot = 6; b_kind[6] = 2'b01; b_jr = upto(6);
    b_ptgt = b_pc[6] + sext(b_off[6]); apply("R10");
    // R3: missed JAL, not taken
    base(); b_kind[5] = 2'b10; apply("R3");
    // R3: JAL before the taken slot
    base(); b_kind[5] = 2'b10; b_kind[9] = 2'b01; b_taken = 1; b_pslot = 9;
    b_jr = upto(9); b_ptgt = b_pc[9] + sext(b_off[9]); apply("R3");
    // R3: JAL outside range not flagged
    base(); b_kind[12] = 2'b10; b_fr = upto(10); apply("R3");
    // R7: JAL predicted, wrong target
    base(); b_kind[5] = 2'b10; b_taken = 1; b_pslot = 5; b_jr = upto(5);
    b_ptgt = 32'h1234_5678; apply("R7");
    // R7: branch with negative offset, wrong target
    base(); b_kind[11] = 2'b01; b_off[11] = 13'h1F00; b_taken = 1; b_pslot = 11;
    b_jr = upto(11); b_ptgt = b_pc[11] + 32'h10; apply("R7");
    // R7: JALR at predicted slot never faults
    base(); b_kind[4] = 2'b11; b_taken = 1; b_pslot = 4; b_jr = upto(4);
    b_ptgt = 32'hDEAD_0000; apply("R7");
    // R4: missed return
    base(); b_kind[3] = 2'b11; b_retf[3] = 1; apply("R4");
    // R5: prediction on second half of a 32-bit instruction
    base(); b_rvc[7] = 0; b_start[8] = 0; b_taken = 1; b_pslot = 8;
    b_kind[8] = 2'b01; b_jr = upto(8); apply("R5");
    // R5: prediction outside range
    base(); b_taken = 1; b_pslot = 10; b_jr = upto(6); b_rvc[10] = 0; apply("R5");
    // R6: prediction on non-CFI slot, 32-bit instruction
    base(); b_taken = 1; b_pslot = 2; b_rvc[2] = 0; b_start[3] = 0; b_jr = upto(2);
    apply("R6");
    // R8: several faults, lowest wins
    base(); b_kind[2] = 2'b10; b_kind[7] = 2'b11; b_retf[7] = 1; b_kind[9] = 2'b10;
    apply("R8");
    // R8, R9: return first then JAL, taken at 12 on non-CFI
    base(); b_kind[4] = 2'b11; b_retf[4] = 1; b_kind[8] = 2'b10; b_taken = 1;
    b_pslot = 12; b_jr = upto(12); apply("R9");
    // R1: idle cycle
    base(); b_valid = 0; b_kind[5] = 2'b10; apply("R1");

    // R8: random blocks
    for (int n = 0; n < 600; n++) begin
      base();
      b_valid = ($urandom % 8) != 0;
      for (int i = 0; i < N; i++) begin
        b_kind[i]  = 2'($urandom % 4);
        b_start[i] = ($urandom % 6) != 0;
        b_rvc[i]   = 1'($urandom % 2);
        b_retf[i]  = 1'($urandom % 2);
        b_off[i]   = 13'($urandom);
      end
      if (($urandom % 3) == 0)
        for (int i = 0; i < N; i++) if (b_kind[i] == 2'b10) b_kind[i] = 2'b00;
      b_taken = 1'($urandom % 2);
      b_pslot = 4'($urandom % 16);
      b_jr = (($urandom % 4) == 0) ? upto(int'($urandom % 16)) : upto(int'(b_pslot));
      b_fr = upto(int'($urandom % 16));
      b_ptgt = ($urandom % 2) ? b_pc[b_pslot] + sext(b_off[b_pslot]) : $urandom;
      b_ret_addr = $urandom;
      apply("R8");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule